// File: doc/BRIEF.md
# Split-View Doorbell Mailbox

This block passes doorbell signals from a sending processor to a receiving processor. Each side has its own small memory-mapped port with a register window of its own. The design has a build-time number of one-way channels. Each channel holds a 32-bit status word. The sender raises status bits. The receiver reads the word and clears bits. Each channel drives one interrupt line to the receiver, and that line stays high while any bit in the channel's word is set.

A wake-up handshake sits in front of the doorbells. The sender writes a request bit, and the block drives that bit out as a wake request toward the receiver's power logic. The receiver side answers with an acknowledge. The sender reads the acknowledge back as a ready bit. The block accepts set writes only while ready is high. When the sender drops the request, the block stops asking, but it never forces the receiver to sleep.

Each channel has a 0x20-byte window in both views. Both views also carry a read-only register that reports the channel count.

Top module: `dbell_mbox`

## Requirements
- R1: After reset, every status word is zero, every interrupt is low, the wake request is low and the ready bit (sender offset 0xF8C, bit 0) reads 0.
- R2: A read of offset 0xF80 returns the channel count parameter, in both the sender view and the receiver view.
- R3: A sender write to channel c at offset c*0x20+0xC ORs the write data into that channel's status word. The status word reads back at offset c*0x20+0x0 in both views.
- R4: A receiver write to offset c*0x20+0x8 clears each status bit of channel c that is written as 1. Bits written as 0 are left unchanged.
- R5: The sender set register and the receiver clear register both read as zero.
- R6: The interrupt bit c of `rcv_irq` is high in exactly the cycles when the status word of channel c is nonzero.
- R7: When a set and a clear reach the same status bit in the same cycle, the bit ends up set.
- R8: Bit 0 of sender offset 0xF88 holds the wake request. It reads back and drives `wake_req`. Writing 0 drops `wake_req` on the next clock.
- R9: The ready bit is `wake_ack` registered one clock, and only counts while the request is held. It is read-only: writes to 0xF8C change nothing.
- R10: A set write is dropped while the ready bit reads 0.
- R11: Any read of an undefined offset returns zero, and any write to it is ignored. This covers the words at +0x4 in the channel windows, channel windows at or beyond the channel count, and 0xF88/0xF8C in the receiver view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_sel | input | 1 | Sender access strobe |
| snd_wr | input | 1 | Sender write (1) or read (0) |
| snd_addr | input | 12 | Sender byte address |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data, one clock after the strobe |
| rcv_sel | input | 1 | Receiver access strobe |
| rcv_wr | input | 1 | Receiver write (1) or read (0) |
| rcv_addr | input | 12 | Receiver byte address |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data, one clock after the strobe |
| rcv_irq | output | NCH | One interrupt per channel toward the receiver |
| wake_req | output | 1 | Wake-up request toward the receiver |
| wake_ack | input | 1 | Receiver acknowledge of the wake request |

## Verification
The bench drives set patterns that do not overlap earlier bits, so the result shows whether status is merged with OR or simply overwritten. It drives partial clear masks, so the result shows a bitwise clear apart from a clear of the whole word. In one cycle it drives a set and a clear that overlap on some bits, which shows which side has priority. It also sends set writes before the handshake completes, to undefined words and to channel windows past the channel count. These tell a correct gate and a correct decoder apart from a decoder that aliases addresses or accepts writes too freely.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int ADDR_W   = 12;
  localparam int WIN_SH   = 5;              // 0x20-byte channel window
  localparam logic [ADDR_W-1:0] A_CAP  = 12'hF80;
  localparam logic [ADDR_W-1:0] A_WREQ = 12'hF88;
  localparam logic [ADDR_W-1:0] A_WRDY = 12'hF8C;
  localparam logic [WIN_SH-1:0] O_STAT = 5'h00;
  localparam logic [WIN_SH-1:0] O_SET  = 5'h0C;
  localparam logic [WIN_SH-1:0] O_CLR  = 5'h08;

  // channel index of a byte address
  function automatic int win_index(input logic [ADDR_W-1:0] a);
    return int'(a >> WIN_SH);
  endfunction

  // offset inside the channel window
  function automatic logic [WIN_SH-1:0] win_off(input logic [ADDR_W-1:0] a);
    return a[WIN_SH-1:0];
  endfunction

  // true when address a hits register off of channel c
  function automatic logic chan_hit(input logic [ADDR_W-1:0] a, input int c,
                                    input logic [WIN_SH-1:0] off);
    return (win_index(a) == c) && (win_off(a) == off);
  endfunction
endpackage

// File: rtl/dbm_wake.sv
module dbm_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_bit,
  input  logic ack_i,
  output logic req_q,
  output logic rdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (req_wr) req_q <= req_bit;
      rdy_q <= ack_i & req_q;
    end
  end
endmodule

// File: rtl/dbm_chan_bank.sv
module dbm_chan_bank #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH*DW-1:0] set_flat,
  input  logic [NCH*DW-1:0] clr_flat,
  output logic [NCH*DW-1:0] status_flat,
  output logic [NCH-1:0]    irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= (st & ~clr_flat[c*DW +: DW]) | set_flat[c*DW +: DW];
    end
    assign status_flat[c*DW +: DW] = st;
    assign irq[c] = |st;
  end
endmodule

// File: rtl/dbm_snd_port.sv
module dbm_snd_port
  import dbm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*DW-1:0] status_flat,
  input  logic              rdy,
  input  logic              req_q,
  output logic [NCH*DW-1:0] set_flat,
  output logic              req_wr,
  output logic              req_bit
);
  logic [DW-1:0] rd_next;

  always_comb begin
    set_flat = '0;
    for (int c = 0; c < NCH; c++)
      if (sel && wr && rdy && chan_hit(addr, c, O_SET))
        set_flat[c*DW +: DW] = wdata;
  end

  assign req_wr  = sel && wr && (addr == A_WREQ);
  assign req_bit = wdata[0];

  always_comb begin
    rd_next = '0;
    if (addr == A_CAP)       rd_next = DW'(NCH);
    else if (addr == A_WREQ) rd_next = {{(DW-1){1'b0}}, req_q};
    else if (addr == A_WRDY) rd_next = {{(DW-1){1'b0}}, rdy};
    else
      for (int c = 0; c < NCH; c++)
        if (chan_hit(addr, c, O_STAT)) rd_next = status_flat[c*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (sel && !wr) rdata <= rd_next;
  end
endmodule

// File: rtl/dbm_rcv_port.sv
module dbm_rcv_port
  import dbm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*DW-1:0] status_flat,
  output logic [NCH*DW-1:0] clr_flat
);
  logic [DW-1:0] rd_next;

  always_comb begin
    clr_flat = '0;
    for (int c = 0; c < NCH; c++)
      if (sel && wr && chan_hit(addr, c, O_CLR))
        clr_flat[c*DW +: DW] = wdata;
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_CAP) rd_next = DW'(NCH);
    else
      for (int c = 0; c < NCH; c++)
        if (chan_hit(addr, c, O_STAT)) rd_next = status_flat[c*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (sel && !wr) rdata <= rd_next;
  end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
  import dbm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_sel,
  input  logic              snd_wr,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic [DW-1:0]     snd_wdata,
  output logic [DW-1:0]     snd_rdata,
  input  logic              rcv_sel,
  input  logic              rcv_wr,
  input  logic [ADDR_W-1:0] rcv_addr,
  input  logic [DW-1:0]     rcv_wdata,
  output logic [DW-1:0]     rcv_rdata,
  output logic [NCH-1:0]    rcv_irq,
  output logic              wake_req,
  input  logic              wake_ack
);
  localparam int SW = NCH * DW;

  // named internal events, visible to the checker
  logic [SW-1:0] set_flat;
  logic [SW-1:0] clr_flat;
  logic [SW-1:0] status_flat;
  logic          req_wr;
  logic          req_bit;
  logic          req_q;
  logic          rdy_q;

  dbm_snd_port #(.NCH(NCH), .DW(DW)) u_snd (
    .clk(clk), .rst_n(rst_n), .sel(snd_sel), .wr(snd_wr), .addr(snd_addr),
    .wdata(snd_wdata), .rdata(snd_rdata), .status_flat(status_flat),
    .rdy(rdy_q), .req_q(req_q), .set_flat(set_flat), .req_wr(req_wr),
    .req_bit(req_bit));

  dbm_rcv_port #(.NCH(NCH), .DW(DW)) u_rcv (
    .clk(clk), .rst_n(rst_n), .sel(rcv_sel), .wr(rcv_wr), .addr(rcv_addr),
    .wdata(rcv_wdata), .rdata(rcv_rdata), .status_flat(status_flat),
    .clr_flat(clr_flat));

  dbm_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_flat(set_flat), .clr_flat(clr_flat),
    .status_flat(status_flat), .irq(rcv_irq));

  dbm_wake u_wake (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bit(req_bit),
    .ack_i(wake_ack), .req_q(req_q), .rdy_q(rdy_q));

  assign wake_req = req_q;
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    rcv_irq,
  input logic              wake_req,
  input logic              rdy_q,
  input logic              req_wr,
  input logic [NCH*DW-1:0] status_flat,
  input logic [NCH*DW-1:0] set_flat,
  input logic [NCH*DW-1:0] clr_flat
);
  // R3: an interrupt only rises after a set pulse
  p_rise_after_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rcv_irq & ~$past(rcv_irq)) != '0) |-> ($past(set_flat) != '0));

  // R4: an interrupt only falls after a clear pulse
  p_fall_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rcv_irq & $past(rcv_irq)) != '0) |-> ($past(clr_flat) != '0));

  // R7: overlapping set and clear leave the bits set
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_flat & clr_flat) != '0) |=>
      ((status_flat & $past(set_flat & clr_flat)) == $past(set_flat & clr_flat)));

  // R8: the request only drops after a sender write to the request register
  p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req) |-> $past(req_wr));

  // R9: ready is only seen while the request was held
  p_ready_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> $past(wake_req));

  // R10: no new status bits while ready was low
  p_no_set_unready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdy_q) |-> ((status_flat & ~$past(status_flat)) == '0));
endmodule

bind dbell_mbox dbell_mbox_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rcv_irq(rcv_irq), .wake_req(wake_req),
  .rdy_q(rdy_q), .req_wr(req_wr), .status_flat(status_flat),
  .set_flat(set_flat), .clr_flat(clr_flat));

// File: tb/dbell_mbox_bench.sv
module dbell_mbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snd_sel = 0, snd_wr = 0, rcv_sel = 0, rcv_wr = 0;
  logic [AW-1:0] snd_addr = '0, rcv_addr = '0;
  logic [DW-1:0] snd_wdata = '0, rcv_wdata = '0;
  logic [DW-1:0] snd_rdata, rcv_rdata;
  logic [NCH-1:0] rcv_irq;
  logic wake_req;
  logic wake_ack;
  logic [2:0] ack_sr = '0;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_mbox #(.NCH(NCH), .DW(DW)) u_dbell_mbox (
    .clk(clk), .rst_n(rst_n),
    .snd_sel(snd_sel), .snd_wr(snd_wr), .snd_addr(snd_addr),
    .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_sel(rcv_sel), .rcv_wr(rcv_wr), .rcv_addr(rcv_addr),
    .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .rcv_irq(rcv_irq), .wake_req(wake_req), .wake_ack(wake_ack));

  // receiver power model: acknowledge arrives three clocks after the request
  always @(posedge clk) ack_sr <= {ack_sr[1:0], wake_req};
  assign wake_ack = ack_sr[2];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [DW-1:0] snd_q[$];
  string         snd_t[$];
  logic [DW-1:0] rcv_q[$];
  string         rcv_t[$];
  logic snd_pend = 0, rcv_pend = 0;

  always @(posedge clk) begin
    snd_pend <= snd_sel && !snd_wr;
    rcv_pend <= rcv_sel && !rcv_wr;
  end

  always @(negedge clk) begin
    if (snd_pend && snd_q.size() > 0) chk(snd_t.pop_front(), snd_rdata, snd_q.pop_front());
    if (rcv_pend && rcv_q.size() > 0) chk(rcv_t.pop_front(), rcv_rdata, rcv_q.pop_front());
  end

  task automatic s_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    snd_sel = 1; snd_wr = 1; snd_addr = a; snd_wdata = d;
    @(negedge clk);
    snd_sel = 0; snd_wr = 0;
  endtask

  task automatic r_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    rcv_sel = 1; rcv_wr = 1; rcv_addr = a; rcv_wdata = d;
    @(negedge clk);
    rcv_sel = 0; rcv_wr = 0;
  endtask

  task automatic both_wr(input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                         input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    snd_sel = 1; snd_wr = 1; snd_addr = sa; snd_wdata = sd;
    rcv_sel = 1; rcv_wr = 1; rcv_addr = ra; rcv_wdata = rd;
    @(negedge clk);
    snd_sel = 0; snd_wr = 0; rcv_sel = 0; rcv_wr = 0;
  endtask

  task automatic s_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    snd_q.push_back(exp); snd_t.push_back(tag);
    snd_sel = 1; snd_wr = 0; snd_addr = a;
    @(negedge clk);
    snd_sel = 0;
  endtask

  task automatic r_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    rcv_q.push_back(exp); rcv_t.push_back(tag);
    rcv_sel = 1; rcv_wr = 0; rcv_addr = a;
    @(negedge clk);
    rcv_sel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", DW'(rcv_irq), '0);
    chk("R1 wake_req", DW'(wake_req), '0);
    s_rd(12'h020, 32'h0, "R1 status ch1");
    s_rd(12'hF8C, 32'h0, "R1 ready");
    // R2 capability in both views
    s_rd(12'hF80, 32'd4, "R2 cap snd");
    r_rd(12'hF80, 32'd4, "R2 cap rcv");
    // R10 set before handshake is dropped
    s_wr(12'h02C, 32'h0000_00A5);
    s_rd(12'h020, 32'h0, "R10 set dropped");
    chk("R10 irq low", DW'(rcv_irq), '0);
    // R8 request
    s_wr(12'hF88, 32'h1);
    chk("R8 wake_req high", DW'(wake_req), 32'h1);
    s_rd(12'hF88, 32'h1, "R8 req readback");
    repeat (8) @(negedge clk);
    s_rd(12'hF8C, 32'h1, "R9 ready");
    // R9 ready is read-only
    s_wr(12'hF8C, 32'h0);
    s_rd(12'hF8C, 32'h1, "R9 ready read-only");
    // R3 OR merge, both views
    s_wr(12'h02C, 32'h0000_00A5);
    s_rd(12'h020, 32'h0000_00A5, "R3 snd status");
    r_rd(12'h020, 32'h0000_00A5, "R3 rcv status");
    chk("R6 irq ch1", DW'(rcv_irq), 32'h2);
    s_wr(12'h02C, 32'h0000_0100);
    r_rd(12'h020, 32'h0000_01A5, "R3 or merge");
    // R5 set/clear read zero
    s_rd(12'h02C, 32'h0, "R5 set reads zero");
    r_rd(12'h028, 32'h0, "R5 clear reads zero");
    // R4 partial clear
    r_wr(12'h028, 32'h0000_0005);
    r_rd(12'h020, 32'h0000_01A0, "R4 partial clear");
    chk("R6 irq still", DW'(rcv_irq), 32'h2);
    r_wr(12'h028, 32'h0000_01A0);
    chk("R6 irq drops", DW'(rcv_irq), 32'h0);
    // R6 high bit on ch3
    s_wr(12'h06C, 32'h8000_0000);
    chk("R6 irq ch3", DW'(rcv_irq), 32'h8);
    r_wr(12'h068, 32'h8000_0000);
    chk("R6 irq ch3 off", DW'(rcv_irq), 32'h0);
    // R7 set wins
    both_wr(12'h04C, 32'h0000_00F0, 12'h048, 32'h0000_00FF);
    s_rd(12'h040, 32'h0000_00F0, "R7 set wins");
    r_wr(12'h048, 32'h0000_00F0);
    // R11 undefined offsets
    s_wr(12'h004, 32'hFFFF_FFFF);
    s_rd(12'h004, 32'h0, "R11 hole reads zero");
    s_rd(12'h000, 32'h0, "R11 hole write ignored");
    s_wr(12'h08C, 32'hFFFF_FFFF);
    chk("R11 beyond count irq", DW'(rcv_irq), 32'h0);
    s_rd(12'h080, 32'h0, "R11 beyond count reads zero");
    r_wr(12'hF88, 32'h0);
    chk("R11 rcv req write ignored", DW'(wake_req), 32'h1);
    r_rd(12'hF8C, 32'h0, "R11 rcv ready hidden");
    r_rd(12'hF88, 32'h0, "R11 rcv req hidden");
    // R8 drop request
    s_wr(12'hF88, 32'h0);
    chk("R8 wake_req low", DW'(wake_req), 32'h0);
    repeat (6) @(negedge clk);
    s_rd(12'hF8C, 32'h0, "R9 ready drops");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule